// File: doc/BRIEF.md
# Two-Cycle DMA Channel Engine

This block is one self-driving DMA channel. After the host loads its configuration and pulses `start`, the channel moves bytes on its own. Each item takes two bus operations: a read from the source pointer into an internal holding register, then a write of that held byte to the destination pointer. Either pointer can advance by one after every item. When translation is switched on, the fetched byte is not stored directly. The channel first reads a table entry at the table base plus the byte value, and it stores that entry instead.

A peripheral request input paces the work. A new item starts only when the request is high at an item boundary. A bus operation that has begun always runs to completion. The run ends on the first of several enabled conditions: a programmed item count, a masked compare on the fetched byte, an external terminate input, or single-item mode. At that point the channel latches a code for the cause and raises an interrupt, which stays high until the host clears it.

The bus side is a plain request/ready port. The request, address, direction and write data are all registered outputs, and they hold steady until ready is seen.

Top module: `xfer_chan`

## Requirements
- R1: Every item is a read (`bus_we_o`=0) from the source pointer, then a write (`bus_we_o`=1) to the destination pointer of the byte that was read, or of its translated value when translation is on. A write begins only in the cycle right after a read completes.
- R2: `mode_i` bit 6 makes the source pointer advance by 1 after each stored item, and bit 5 does the same for the destination pointer. With a bit clear, that pointer stays at its start value.
- R3: When `mode_i` bit 4 is set, each fetched byte b is replaced by the byte read at `tbl_addr_i` + b, and that byte is stored.
- R4: When `mode_i` bit 3 is set, the run ends after the item whose fetched byte b satisfies (b & `mask_i`) == `match_i`. That item is still stored.
- R5: When `mode_i` bit 1 is set, the run ends after `count_i` items have been stored (`count_i` ≥ 1).
- R6: When `mode_i` bit 0 is set, the run ends after exactly one item.
- R7: When `mode_i` bit 2 is set, a high `ext_i` during a run ends the run at the next item boundary. An item already under way is still stored. With bit 2 clear, `ext_i` has no effect.
- R8: `term_code_o` records the cause: 0 count, 1 compare, 2 external, 3 single. When several causes hold at once, priority is external, then compare, then count, then single.
- R9: A new fetch starts only if `dreq_i` was high at the item boundary. Otherwise the channel waits with `bus_req_o` low and `busy_o` high.
- R10: At termination `busy_o` falls and `irq_o` rises. `irq_o` stays high until `irq_clr_i` is pulsed. No bus request is made while the channel is not busy.
- R11: While `bus_req_o` is high and `bus_rdy_i` is low, the address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | latch configuration and begin a run |
| mode_i | input | 7 | channel mode bits (see R2–R7) |
| src_addr_i | input | 20 | source start address |
| dst_addr_i | input | 20 | destination start address |
| tbl_addr_i | input | 20 | translation table base |
| count_i | input | 16 | item count for count termination |
| mask_i | input | 8 | compare mask |
| match_i | input | 8 | compare value |
| dreq_i | input | 1 | peripheral request |
| ext_i | input | 1 | external terminate |
| irq_clr_i | input | 1 | clears the interrupt |
| bus_req_o | output | 1 | bus operation request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 20 | bus address |
| bus_wdata_o | output | 8 | write data |
| bus_rdata_i | input | 8 | read data, valid with ready |
| bus_rdy_i | input | 1 | bus operation completes this cycle |
| busy_o | output | 1 | run in progress |
| irq_o | output | 1 | interrupt toward host |
| term_code_o | output | 2 | cause of last termination |

## Verification
Two cases can decide the same item boundary together. In the first, the count reaches its last item on the same byte that matches the compare. The bench provokes this with a count of 3 and a matching byte in third position, and it expects the compare code. In the second, an external terminate arrives while the store of an item is held by wait states. The bench expects that item to be stored and the external code to win over the count, which is still far from done.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    TC_COUNT  = 2'd0,
    TC_MATCH  = 2'd1,
    TC_EXT    = 2'd2,
    TC_SINGLE = 2'd3
  } term_e;

  typedef struct packed {
    logic src_step;
    logic dst_step;
    logic xlat_on;
    logic match_stop;
    logic ext_stop;
    logic count_stop;
    logic single_shot;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_FETCH, ST_XLAT, ST_STORE
  } state_e;
endpackage

// File: rtl/xc_ptr.sv
module xc_ptr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= ld_val;
    else if (step) q <= q + AW'(1);
  end
endmodule

// File: rtl/xc_count.sv
module xc_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] left_q;
  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= ld_val;
    else if (dec)  left_q <= left_q - CW'(1);
  end
  assign last = (left_q == CW'(1));
endmodule

// File: rtl/xc_term.sv
module xc_term
  import xc_pkg::*;
(
  input  logic  ext_hit,
  input  logic  match_hit,
  input  logic  count_hit,
  input  logic  single_hit,
  output logic  stop,
  output term_e code
);
  always_comb begin
    stop = ext_hit | match_hit | count_hit | single_hit;
    if (ext_hit)        code = TC_EXT;
    else if (match_hit) code = TC_MATCH;
    else if (count_hit) code = TC_COUNT;
    else                code = TC_SINGLE;
  end
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
  import xc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [MW-1:0] mode_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [AW-1:0] tbl_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] match_i,
  input  logic          dreq_i,
  input  logic          ext_i,
  input  logic          irq_clr_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic          busy_o,
  output logic          irq_o,
  output logic [1:0]    term_code_o
);
  state_e        state_q;
  mode_t         mode_q;
  logic [AW-1:0] tbl_q, src_p, dst_p;
  logic [DW-1:0] mask_q, match_q, hold_q;
  logic          hit_q, ext_pend_q;
  logic          store_done, cnt_last, ext_hit, stop;
  term_e         stop_code;

  assign store_done = (state_q == ST_STORE) && bus_rdy_i;
  assign ext_hit    = mode_q.ext_stop && (ext_pend_q || ext_i);
  assign busy_o     = (state_q != ST_IDLE);

  xc_ptr #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(start && !busy_o), .ld_val(src_addr_i),
    .step(store_done && mode_q.src_step), .q(src_p));

  xc_ptr #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(start && !busy_o), .ld_val(dst_addr_i),
    .step(store_done && mode_q.dst_step), .q(dst_p));

  xc_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(start && !busy_o), .ld_val(count_i),
    .dec(store_done), .last(cnt_last));

  xc_term u_term (
    .ext_hit(ext_hit),
    .match_hit(mode_q.match_stop && hit_q),
    .count_hit(mode_q.count_stop && cnt_last),
    .single_hit(mode_q.single_shot),
    .stop(stop), .code(stop_code));

  always_ff @(posedge clk) begin
    if (rst)                         ext_pend_q <= 1'b0;
    else if (start && !busy_o)       ext_pend_q <= 1'b0;
    else if (busy_o && ext_hit)      ext_pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= '0;
      tbl_q       <= '0;
      mask_q      <= '0;
      match_q     <= '0;
      hold_q      <= '0;
      hit_q       <= 1'b0;
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      irq_o       <= 1'b0;
      term_code_o <= 2'd0;
    end else begin
      if (irq_clr_i) irq_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q  <= mode_t'(mode_i);
            tbl_q   <= tbl_addr_i;
            mask_q  <= mask_i;
            match_q <= match_i;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ext_hit) begin
            state_q     <= ST_IDLE;
            irq_o       <= 1'b1;
            term_code_o <= TC_EXT;
          end else if (dreq_i) begin
            bus_req_o  <= 1'b1;
            bus_we_o   <= 1'b0;
            bus_addr_o <= src_p;
            state_q    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (bus_rdy_i) begin
            hold_q <= bus_rdata_i;
            hit_q  <= ((bus_rdata_i & mask_q) == match_q);
            if (mode_q.xlat_on) begin
              bus_addr_o <= tbl_q + AW'(bus_rdata_i);
              state_q    <= ST_XLAT;
            end else begin
              bus_we_o    <= 1'b1;
              bus_addr_o  <= dst_p;
              bus_wdata_o <= bus_rdata_i;
              state_q     <= ST_STORE;
            end
          end
        end
        ST_XLAT: begin
          if (bus_rdy_i) begin
            bus_we_o    <= 1'b1;
            bus_addr_o  <= dst_p;
            bus_wdata_o <= bus_rdata_i;
            state_q     <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (bus_rdy_i) begin
            bus_req_o <= 1'b0;
            bus_we_o  <= 1'b0;
            if (stop) begin
              state_q     <= ST_IDLE;
              irq_o       <= 1'b1;
              term_code_o <= stop_code;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dreq_i,
  input logic          irq_clr_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_rdy_i,
  input logic          busy_o,
  input logic          irq_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req_o && !bus_rdy_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)); // R11
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    bus_req_o && bus_we_o && !$past(bus_we_o) |-> $past(bus_req_o && bus_rdy_i)); // R1
  AST_FETCH_NEEDS_DREQ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_o) |-> $past(dreq_i)); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    irq_o && !irq_clr_i |=> irq_o); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_req_o); // R10
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !busy_o); // R10
endmodule

bind xfer_chan xc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .dreq_i(dreq_i), .irq_clr_i(irq_clr_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_rdy_i(bus_rdy_i), .busy_o(busy_o), .irq_o(irq_o));

// File: tb/xfer_chan_bench.sv
module xfer_chan_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  mode_i = '0;
  logic [19:0] src_addr_i = '0, dst_addr_i = '0, tbl_addr_i = '0;
  logic [15:0] count_i = '0;
  logic [7:0]  mask_i = '0, match_i = '0;
  logic        dreq_i = 1'b1, ext_i = 1'b0, irq_clr_i = 1'b0;
  logic        bus_req_o, bus_we_o, bus_rdy_i = 1'b0, busy_o, irq_o;
  logic [19:0] bus_addr_o;
  logic [7:0]  bus_wdata_o, bus_rdata_i = '0;
  logic [1:0]  term_code_o;

  int checks = 0, failures = 0, wait_n = 0, wcnt = 0;
  logic [7:0] mem [0:1023];

  always #4 clk = ~clk;

  xfer_chan u_xfer_chan (.*);

  always @(negedge clk) begin
    if (bus_req_o) begin
      if (wcnt < wait_n) begin bus_rdy_i = 1'b0; wcnt++; end
      else begin bus_rdy_i = 1'b1; bus_rdata_i = mem[bus_addr_o[9:0]]; wcnt = 0; end
    end else begin
      bus_rdy_i = 1'b0; wcnt = 0;
    end
  end

  always @(posedge clk)
    if (bus_req_o && bus_we_o && bus_rdy_i) mem[bus_addr_o[9:0]] <= bus_wdata_o;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
  endtask

  task automatic launch(input logic [6:0] m, input logic [15:0] n, input logic [7:0] mk, input logic [7:0] mv);
    @(negedge clk);
    mode_i = m; count_i = n; mask_i = mk; match_i = mv;
    src_addr_i = 20'h00000; dst_addr_i = 20'h00100; tbl_addr_i = 20'h00200;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!irq_o && n < 3000) begin @(negedge clk); n++; end
    chk(irq_o === 1'b1, tag, irq_o, 1);
    chk(busy_o === 1'b0, tag, busy_o, 0);
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    chk(irq_o === 1'b0, "R10 irq cleared", irq_o, 0);
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0, "R10 reset busy", busy_o, 0);
    chk(irq_o === 1'b0, "R10 reset irq", irq_o, 0);
    chk(bus_req_o === 1'b0, "R10 reset req", bus_req_o, 0);
  endtask

  task automatic t_count_copy();
    clear_mem();
    for (int i = 0; i < 6; i++) mem[i] = 8'h10 + 8'(i);
    launch(7'b1100010, 16'd4, 8'h00, 8'hFF);
    repeat (5) @(negedge clk);
    chk(irq_o === 1'b0, "R10 irq low mid-run", irq_o, 0);
    wait_end("R5 count end");
    for (int i = 0; i < 4; i++) chk(mem[256+i] == 8'h10 + 8'(i), "R1 R2 copied byte", mem[256+i], 8'h10 + i);
    chk(mem[260] == 8'hEE, "R5 no fifth item", mem[260], 8'hEE);
    chk(term_code_o == 2'd0, "R8 count code", term_code_o, 0);
    ack_irq();
  endtask

  task automatic t_fixed_dst();
    clear_mem();
    for (int i = 0; i < 3; i++) mem[i] = 8'hA0 + 8'(i);
    launch(7'b1000010, 16'd3, 8'h00, 8'hFF);
    wait_end("R2 fixed dst end");
    chk(mem[256] == 8'hA2, "R2 fixed dst last byte", mem[256], 8'hA2);
    chk(mem[257] == 8'hEE, "R2 fixed dst neighbour", mem[257], 8'hEE);
    ack_irq();
  endtask

  task automatic t_xlat();
    clear_mem();
    for (int i = 0; i < 256; i++) mem[512+i] = 8'(i) ^ 8'h5A;
    mem[0] = 8'h03; mem[1] = 8'hF0; mem[2] = 8'h7F;
    launch(7'b1110010, 16'd3, 8'h00, 8'hFF);
    wait_end("R3 xlat end");
    chk(mem[256] == (8'h03 ^ 8'h5A), "R3 xlat 0", mem[256], 8'h03 ^ 8'h5A);
    chk(mem[257] == (8'hF0 ^ 8'h5A), "R3 xlat 1", mem[257], 8'hF0 ^ 8'h5A);
    chk(mem[258] == (8'h7F ^ 8'h5A), "R3 xlat 2", mem[258], 8'h7F ^ 8'h5A);
    ack_irq();
  endtask

  task automatic t_match();
    clear_mem();
    mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h35; mem[3] = 8'h44;
    launch(7'b1101000, 16'd0, 8'hF0, 8'h30);
    wait_end("R4 match end");
    chk(mem[258] == 8'h35, "R4 matching item stored", mem[258], 8'h35);
    chk(mem[259] == 8'hEE, "R4 stops after match", mem[259], 8'hEE);
    chk(term_code_o == 2'd1, "R4 match code", term_code_o, 1);
    ack_irq();
  endtask

  task automatic t_match_and_count();
    clear_mem();
    mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h35; mem[3] = 8'h44;
    launch(7'b1101010, 16'd3, 8'hF0, 8'h30);
    wait_end("R8 tie end");
    chk(term_code_o == 2'd1, "R8 compare beats count", term_code_o, 1);
    chk(mem[259] == 8'hEE, "R8 tie stops", mem[259], 8'hEE);
    ack_irq();
  endtask

  task automatic t_single();
    clear_mem();
    mem[0] = 8'h77; mem[1] = 8'h88;
    launch(7'b1100001, 16'd0, 8'h00, 8'hFF);
    wait_end("R6 single end");
    chk(mem[256] == 8'h77, "R6 one item", mem[256], 8'h77);
    chk(mem[257] == 8'hEE, "R6 only one", mem[257], 8'hEE);
    chk(term_code_o == 2'd3, "R6 single code", term_code_o, 3);
    ack_irq();
  endtask

  task automatic t_stall();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h02;
    dreq_i = 1'b0;
    launch(7'b1100010, 16'd2, 8'h00, 8'hFF);
    repeat (6) @(negedge clk);
    chk(bus_req_o === 1'b0, "R9 no fetch without dreq", bus_req_o, 0);
    chk(busy_o === 1'b1, "R9 busy while stalled", busy_o, 1);
    dreq_i = 1'b1;
    wait_end("R9 resume end");
    chk(mem[257] == 8'h02, "R9 resumed copy", mem[257], 8'h02);
    ack_irq();
  endtask

  task automatic t_ext_idle();
    clear_mem();
    dreq_i = 1'b0;
    launch(7'b1100100, 16'd0, 8'h00, 8'hFF);
    repeat (3) @(negedge clk);
    ext_i = 1'b1; @(negedge clk); ext_i = 1'b0;
    wait_end("R7 ext end");
    chk(term_code_o == 2'd2, "R7 ext code", term_code_o, 2);
    chk(mem[256] == 8'hEE, "R7 nothing moved", mem[256], 8'hEE);
    dreq_i = 1'b1;
    ack_irq();
  endtask

  task automatic t_ext_ignored();
    clear_mem();
    mem[0] = 8'h61; mem[1] = 8'h62;
    launch(7'b1100010, 16'd2, 8'h00, 8'hFF);
    ext_i = 1'b1; @(negedge clk); ext_i = 1'b0;
    wait_end("R7 ignored end");
    chk(term_code_o == 2'd0, "R7 ext ignored code", term_code_o, 0);
    chk(mem[257] == 8'h62, "R7 ext ignored moved", mem[257], 8'h62);
    ack_irq();
  endtask

  task automatic t_ext_in_store();
    int n = 0;
    clear_mem();
    mem[0] = 8'h91; mem[1] = 8'h92;
    wait_n = 3;
    launch(7'b1100110, 16'd9, 8'h00, 8'hFF);
    while (!bus_we_o && n < 200) begin @(negedge clk); n++; end
    ext_i = 1'b1; @(negedge clk); ext_i = 1'b0;
    wait_end("R7 store end");
    chk(mem[256] == 8'h91, "R7 in-flight item stored", mem[256], 8'h91);
    chk(mem[257] == 8'hEE, "R7 stop at boundary", mem[257], 8'hEE);
    chk(term_code_o == 2'd2, "R8 ext beats count", term_code_o, 2);
    wait_n = 0;
    ack_irq();
  endtask

  task automatic t_wait_states();
    clear_mem();
    for (int i = 0; i < 3; i++) mem[i] = 8'hC0 + 8'(i);
    wait_n = 2;
    launch(7'b1100010, 16'd3, 8'h00, 8'hFF);
    wait_end("R11 wait-state end");
    chk(mem[258] == 8'hC2, "R11 copy under wait states", mem[258], 8'hC2);
    wait_n = 0;
    ack_irq();
  endtask

  initial begin
    clear_mem();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count_copy();
    t_fixed_dst();
    t_xlat();
    t_match();
    t_match_and_count();
    t_single();
    t_stall();
    t_ext_idle();
    t_ext_ignored();
    t_ext_in_store();
    t_wait_states();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule